// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses which word of a 128-entry control memory is read next. It holds the control address register, which drives the control memory address, and one return-address register for a single level of microcode subroutine. The control memory and the rest of the control path are combinational, and they feed back the fields of the microinstruction now being read. These fields are a 2-bit condition selector, a 2-bit branch kind and a 7-bit branch target. The block also receives three status flags and the 4-bit opcode of the current machine instruction. On each clock edge the control address register takes one of four values: the current address plus one, the branch target, the saved return address, or an address derived from the opcode.

A test multiplexer reduces the condition selector and the flags to one bit. An action decoder combines that bit with the branch kind and names one of five actions. STEP and LOAD come from a conditional goto, LINK and STEP from a conditional subroutine entry, RESUME from a return, and DISPATCH from an opcode map. A synchronous start input puts the sequencer at the entry of the fetch routine, address 64, and clears the return register.

Top module: `useq_sequencer`

## Requirements
- R1: While `start` is high at a clock edge, the control address becomes 64 and the return register becomes 0.
- R2: Condition selector values pick the tested bit as follows: 0 is constant one, 1 is `flag_ind`, 2 is `flag_sign`, 3 is `flag_zero`.
- R3: Branch kind 0 (goto) with the tested bit 1 loads `br_target` into the control address (action LOAD).
- R4: With branch kind 0 or 1 and the tested bit 0, the control address increments by one (action STEP). Address 127 wraps to 0.
- R5: Branch kind 1 (subroutine entry) with the tested bit 1 loads `br_target`. It also stores the current address plus one, modulo 128, in the return register (action LINK).
- R6: Branch kind 1 with the tested bit 0 leaves the return register unchanged.
- R7: Branch kind 2 (return) loads the return register into the control address, whatever the condition selector, the flags and `br_target` hold (action RESUME).
- R8: Branch kind 3 (dispatch) loads the control address with {0, opcode[3:0], 00}, so opcode n lands at 4·n, whatever the condition selector, the flags and `br_target` hold (action DISPATCH).
- R9: The return register changes only on a taken subroutine entry or on `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single-phase clock; both registers update on its rising edge |
| start | input | 1 | Synchronous start; restarts at the fetch entry |
| cond_sel | input | 2 | Condition selector field of the current microinstruction |
| br_kind | input | 2 | Branch kind field: 0 goto, 1 subroutine entry, 2 return, 3 dispatch |
| br_target | input | 7 | Branch target field of the current microinstruction |
| flag_ind | input | 1 | Indirect-address bit of the fetched instruction |
| flag_sign | input | 1 | Sign bit of the accumulator |
| flag_zero | input | 1 | High when every accumulator bit is zero |
| opcode | input | 4 | Operation code of the current machine instruction |
| car_q | output | 7 | Control address register, the control memory address |
| sbr_q | output | 7 | Subroutine return register |

## Verification
An internal fault in this block appears at the ports by the next clock edge. Either the control address register takes a value other than the one the branch kind, the tested bit and the fields select, or the return register moves when it should hold. A fault in the test multiplexer shows only when the selected flag differs from the other flags, so the stimulus drives each selector with the flags set against each other. A return register that was stored wrongly stays hidden until the next return. For this reason each subroutine entry is later followed by a return, and the register is also compared directly on every cycle.

// File: rtl/useq_pkg.sv
package useq_pkg;

    // Branch kind field of a microinstruction
    typedef enum logic [1:0] {
        BR_GOTO     = 2'd0,
        BR_SUB      = 2'd1,
        BR_BACK     = 2'd2,
        BR_DISPATCH = 2'd3
    } br_kind_e;

    // Condition selector field of a microinstruction
    typedef enum logic [1:0] {
        CND_ALWAYS = 2'd0,
        CND_IND    = 2'd1,
        CND_SIGN   = 2'd2,
        CND_ZERO   = 2'd3
    } cond_e;

    // Action chosen by the sequencer for the coming edge
    typedef enum logic [2:0] {
        ACT_STEP     = 3'd0,
        ACT_LOAD     = 3'd1,
        ACT_LINK     = 3'd2,
        ACT_RESUME   = 3'd3,
        ACT_DISPATCH = 3'd4
    } act_e;

endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
    import useq_pkg::*;
(
    input  cond_e cond_sel,
    input  logic  flag_ind,
    input  logic  flag_sign,
    input  logic  flag_zero,
    output logic  test
);

    always_comb begin
        unique case (cond_sel)
            CND_ALWAYS: test = 1'b1;
            CND_IND:    test = flag_ind;
            CND_SIGN:   test = flag_sign;
            CND_ZERO:   test = flag_zero;
            default:    test = 1'b1;
        endcase
    end

endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel
    import useq_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int OPC_W  = 4,
    parameter int SLOT_W = 2
) (
    input  br_kind_e          br_kind,
    input  logic              test,
    input  logic [ADDR_W-1:0] car,
    input  logic [ADDR_W-1:0] sbr,
    input  logic [ADDR_W-1:0] target,
    input  logic [OPC_W-1:0]  opcode,
    output act_e              act,
    output logic [ADDR_W-1:0] car_nxt,
    output logic              sbr_load,
    output logic [ADDR_W-1:0] sbr_nxt
);

    localparam int PAD_W = ADDR_W - OPC_W - SLOT_W;

    logic [ADDR_W-1:0] car_inc;
    logic [ADDR_W-1:0] map_addr;

    assign car_inc = car + 1'b1;

    generate
        if (PAD_W > 0) begin : g_pad
            assign map_addr = {{PAD_W{1'b0}}, opcode, {SLOT_W{1'b0}}};
        end else begin : g_nopad
            assign map_addr = {opcode, {SLOT_W{1'b0}}};
        end
    endgenerate

    // Action decode
    always_comb begin
        unique case (br_kind)
            BR_GOTO:     act = test ? ACT_LOAD : ACT_STEP;
            BR_SUB:      act = test ? ACT_LINK : ACT_STEP;
            BR_BACK:     act = ACT_RESUME;
            BR_DISPATCH: act = ACT_DISPATCH;
            default:     act = ACT_STEP;
        endcase
    end

    // Source multiplexer
    always_comb begin
        sbr_load = 1'b0;
        sbr_nxt  = car_inc;
        unique case (act)
            ACT_STEP:     car_nxt = car_inc;
            ACT_LOAD:     car_nxt = target;
            ACT_LINK: begin
                car_nxt  = target;
                sbr_load = 1'b1;
            end
            ACT_RESUME:   car_nxt = sbr;
            ACT_DISPATCH: car_nxt = map_addr;
            default:      car_nxt = car_inc;
        endcase
    end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int          ADDR_W     = 7,
    parameter int          OPC_W      = 4,
    parameter int          SLOT_W     = 2,
    parameter int unsigned START_ADDR = 64
) (
    input  logic              clk,
    input  logic              start,
    input  logic [1:0]        cond_sel,
    input  logic [1:0]        br_kind,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              flag_ind,
    input  logic              flag_sign,
    input  logic              flag_zero,
    input  logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] car_q,
    output logic [ADDR_W-1:0] sbr_q
);

    localparam logic [ADDR_W-1:0] START_VAL = ADDR_W'(START_ADDR);
    localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};
    localparam int                PAD_W     = ADDR_W - OPC_W - SLOT_W;

    logic              test;
    act_e              act;
    logic [ADDR_W-1:0] car_nxt;
    logic [ADDR_W-1:0] sbr_nxt;
    logic              sbr_load;

    useq_cond_mux u_cond (
        .cond_sel  (cond_e'(cond_sel)),
        .flag_ind  (flag_ind),
        .flag_sign (flag_sign),
        .flag_zero (flag_zero),
        .test      (test)
    );

    useq_next_sel #(
        .ADDR_W (ADDR_W),
        .OPC_W  (OPC_W),
        .SLOT_W (SLOT_W)
    ) u_next (
        .br_kind  (br_kind_e'(br_kind)),
        .test     (test),
        .car      (car_q),
        .sbr      (sbr_q),
        .target   (br_target),
        .opcode   (opcode),
        .act      (act),
        .car_nxt  (car_nxt),
        .sbr_load (sbr_load),
        .sbr_nxt  (sbr_nxt)
    );

    // Register process
    always_ff @(posedge clk) begin
        if (start) begin
            car_q <= START_VAL;
            sbr_q <= '0;
        end else begin
            car_q <= car_nxt;
            if (sbr_load) sbr_q <= sbr_nxt;
        end
    end

    // R1: start lands on the fetch entry with a cleared return register
    assert_start_entry_R1: assert property (@(posedge clk)
        start |=> (car_q == START_VAL && sbr_q == '0));

    // R3: a taken goto follows the target field
    assert_goto_target_R3: assert property (@(posedge clk) disable iff (start)
        (br_kind == 2'd0 && test) |=> car_q == $past(br_target));

    // R4: the step from the top address wraps to zero
    assert_step_wrap_R4: assert property (@(posedge clk) disable iff (start)
        (br_kind[1] == 1'b0 && !test && car_q == TOP_ADDR) |=> car_q == '0);

    // R5: a taken entry saves the address after the current one
    assert_link_save_R5: assert property (@(posedge clk) disable iff (start)
        (br_kind == 2'd1 && test) |=> sbr_q == $past(car_q) + 1'b1);

    // R7: return resumes at the saved address
    assert_resume_R7: assert property (@(posedge clk) disable iff (start)
        (br_kind == 2'd2) |=> car_q == $past(sbr_q));

    // R8: dispatch lands on the opcode slot
    assert_dispatch_R8: assert property (@(posedge clk) disable iff (start)
        (br_kind == 2'd3) |=>
            (car_q[SLOT_W+OPC_W-1:SLOT_W] == $past(opcode) &&
             car_q[SLOT_W-1:0] == '0 &&
             (PAD_W == 0 || (car_q >> (SLOT_W + OPC_W)) == '0)));

    // R6, R9: the return register holds unless an entry is taken
    assert_sbr_hold_R9: assert property (@(posedge clk) disable iff (start)
        !(br_kind == 2'd1 && test) |=> $stable(sbr_q));

    // R2: the tested bit reflects the chosen condition
    assert_cond_pick_R2: assert property (@(posedge clk) disable iff (start)
        (cond_sel == 2'd0) |-> test);

endmodule

// File: tb/useq_sequencer_bench.sv
`timescale 1ns/1ps
module useq_sequencer_bench;

    logic       clk = 1'b0;
    logic       start;
    logic [1:0] cond_sel;
    logic [1:0] br_kind;
    logic [6:0] br_target;
    logic       flag_ind, flag_sign, flag_zero;
    logic [3:0] opcode;
    logic [6:0] car_q, sbr_q;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Reference model state
    int m_car = 0;
    int m_sbr = 0;

    always #2.5 clk = ~clk;

    useq_sequencer u_useq_sequencer (
        .clk       (clk),
        .start     (start),
        .cond_sel  (cond_sel),
        .br_kind   (br_kind),
        .br_target (br_target),
        .flag_ind  (flag_ind),
        .flag_sign (flag_sign),
        .flag_zero (flag_zero),
        .opcode    (opcode),
        .car_q     (car_q),
        .sbr_q     (sbr_q)
    );

    function automatic int tested(int c, bit fi, bit fs, bit fz);
        case (c)
            0: return 1;
            1: return int'(fi);
            2: return int'(fs);
            default: return int'(fz);
        endcase
    endfunction

    task automatic compare(string tag);
        checks++;
        if (int'(car_q) != m_car || int'(sbr_q) != m_sbr) begin
            errors++;
            $display("FAIL %s: car=%0d sbr=%0d expected car=%0d sbr=%0d",
                     tag, car_q, sbr_q, m_car, m_sbr);
        end
    endtask

    // One microinstruction cycle: drive at negedge, model at posedge, check at next negedge
    task automatic step(string tag, int bk, int cs, int tgt, int op,
                        bit fi, bit fs, bit fz);
        int t;
        start = 1'b0; br_kind = 2'(bk); cond_sel = 2'(cs); br_target = 7'(tgt);
        opcode = 4'(op); flag_ind = fi; flag_sign = fs; flag_zero = fz;
        @(posedge clk);
        t = tested(cs, fi, fs, fz);
        case (bk)
            0: m_car = t != 0 ? tgt : (m_car + 1) % 128;
            1: if (t != 0) begin m_sbr = (m_car + 1) % 128; m_car = tgt; end
               else m_car = (m_car + 1) % 128;
            2: m_car = m_sbr;
            default: m_car = op * 4;
        endcase
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_start(string tag);
        start = 1'b1; br_kind = 2'd3; cond_sel = 2'd0; br_target = 7'd5; opcode = 4'd9;
        flag_ind = 1'b1; flag_sign = 1'b1; flag_zero = 1'b1;
        @(posedge clk);
        m_car = 64; m_sbr = 0;
        @(negedge clk);
        compare(tag);
        start = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        start = 1'b1; br_kind = 0; cond_sel = 0; br_target = 0; opcode = 0;
        flag_ind = 0; flag_sign = 0; flag_zero = 0;
        @(negedge clk);
        do_start("R1 reset state");
        // R2, R3: always-true condition with all flags low
        step("R3 goto always", 0, 0, 5, 0, 0, 0, 0);
        // R2, R4: indirect low, others high -> step
        step("R2 ind low steps", 0, 1, 40, 0, 0, 1, 1);
        step("R2 ind high loads", 0, 1, 40, 0, 1, 0, 0);
        step("R2 sign low steps", 0, 2, 90, 0, 1, 0, 1);
        step("R2 sign high loads", 0, 2, 90, 0, 0, 1, 0);
        step("R2 zero low steps", 0, 3, 12, 0, 1, 1, 0);
        step("R2 zero high loads", 0, 3, 12, 0, 0, 0, 1);
        // R5, R7: entry then return
        step("R5 entry taken", 1, 1, 70, 0, 1, 0, 0);
        step("R6 entry inside", 0, 0, 71, 0, 0, 0, 0);
        step("R7 return ignores fields", 2, 3, 99, 7, 0, 1, 0);
        // R6: entry not taken keeps return register
        step("R6 entry not taken", 1, 2, 33, 0, 1, 0, 1);
        // R8: dispatch extremes, fields ignored
        step("R8 dispatch op0", 3, 3, 127, 0, 0, 0, 0);
        step("R8 dispatch op15", 3, 1, 127, 15, 0, 1, 1);
        step("R8 dispatch op6", 3, 2, 1, 6, 1, 0, 0);
        // R4: wrap at the top
        step("R3 goto 127", 0, 0, 127, 0, 0, 0, 0);
        step("R4 wrap to 0", 0, 1, 50, 0, 0, 1, 1);
        step("R3 goto 127 again", 0, 0, 127, 0, 0, 0, 0);
        step("R4 entry not taken wrap", 1, 3, 50, 0, 1, 1, 0);
        step("R3 goto 127 third", 0, 0, 127, 0, 0, 0, 0);
        // R5: entry from the top saves 0
        step("R5 entry at top saves 0", 1, 0, 20, 0, 0, 0, 0);
        step("R7 return to 0", 2, 0, 20, 0, 0, 0, 0);
        // R1: start mid-run
        step("R5 entry before start", 1, 0, 30, 0, 0, 0, 0);
        do_start("R1 start mid-run");
        // R9: random mix
        for (int i = 0; i < 400; i++) begin
            step("R9 random mix", int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 127)), int'($urandom_range(0, 15)),
                 1'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule